// File: doc/BRIEF.md
# Acceleration Sample Register Bank with Status Flags and Peak Capture

This block keeps the latest acceleration sample for each of three axes and presents each one as a 16-bit output word. Every time the sampling path raises its valid strobe, the three 10-bit two's-complement samples are stored. The word of each axis also carries a fresh-data flag and an alert flag. The fresh-data flag is raised by each sample update and dropped when the serial interface reads that axis. The alert flag copies a summary of the diagnostic error flags.

Next to the live words, the block can keep two kinds of peak. The first is a per-axis peak: the sample with the largest magnitude seen on that axis, stored with its sign. The second is a combined peak: the largest scaled sum of squares of the three axes. Each kind has its own enable input. A single clear command resets all four peak registers. The serial interface reads the words in parallel, and it drives one read strobe per axis when it fetches that axis word.

Top module: `accel_sample_regs`

## Requirements
- R1: Axis k takes its sample from `sample_bus[10k+9:10k]` and shows its word on `axis_words[16k+15:16k]`, where x is axis 0, y is axis 1 and z is axis 2. In each axis word, bit 15 is the fresh-data flag, bit 14 is the alert flag, bits 13:10 are always 0, and bits 9:0 hold the last sample stored for that axis.
- R2: When `sample_valid` is 1 at a rising clock edge, all three samples are stored and appear in bits 9:0 of their words after that edge.
- R3: When `rd_strobe[k]` is 1 and `sample_valid` is 0 at an edge, the fresh-data flag of axis k becomes 0 after that edge. The flags of the other axes are not changed. A sample update sets all three flags to 1.
- R4: When a read strobe and `sample_valid` are both 1 at the same edge, the fresh-data flag of that axis is 1 after that edge.
- R5: Bit 14 of every axis word equals `diag_err` in the same cycle.
- R6: While reset is asserted and until the first sample update, all axis words, all peak words and `sos_word` are 0.
- R7: When `peak_en` and `sample_valid` are both 1 at an edge, the peak of axis k takes that axis's sample if the sample's magnitude is strictly larger than the magnitude of the stored peak. Magnitudes are taken as two's complement, so 0x200 has magnitude 512. On equal magnitudes the stored value is kept. The peak word for axis k sits at `peak_words[16k+15:16k]`: the signed peak is in bits 9:0 and bits 15:10 are 0.
- R8: When `peak_en` is 0, sample updates leave the per-axis peaks unchanged.
- R9: When `sos_en` and `sample_valid` are both 1 at an edge, the block forms (x²+y²+z²) >> 8 from the signed samples and clamps it to 0xFFF. If that value is larger than the stored combined peak, it replaces the stored peak. `sos_word` holds the combined peak in bits 11:0, and bits 15:12 are 0.
- R10: When `sos_en` is 0, sample updates leave the combined peak unchanged.
- R11: When `peak_clr` is 1 at an edge, all three per-axis peaks and the combined peak are 0 after that edge. This takes priority over any capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Strobe marking a new set of axis samples |
| sample_bus | input | 30 | Three 10-bit two's-complement samples, axis 0 in the low bits |
| rd_strobe | input | 3 | One read strobe per axis word |
| diag_err | input | 1 | Summary of the active diagnostic errors |
| peak_en | input | 1 | Enables per-axis peak capture |
| sos_en | input | 1 | Enables combined sum-of-squares peak capture |
| peak_clr | input | 1 | Clears all peak registers |
| axis_words | output | 48 | Three axis words holding flags and data |
| peak_words | output | 48 | Three signed per-axis peak words |
| sos_word | output | 16 | Combined sum-of-squares peak word |

## Verification
A flag state that is wrong shows up in bit 15 of the affected word in the cycle right after the faulty read or update. A magnitude compare that is wrong shows up in the peak word after the first sample whose size lies near the stored peak. The directed cases exercise several edges of the magnitude rule: opposite signs with equal magnitude, the most negative code, and a read that collides with an update. The combined peak is compared on every cycle. Any error in a square, the sum or the shift therefore shows up after the first larger sample that reaches it, and from then on it stays visible in `sos_word`.

// File: rtl/accel_pkg.sv
package accel_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned ND_POS = 15;
    localparam int unsigned EA_POS = 14;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/axis_channel.sv
module axis_channel
    import accel_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                rd,
    input  logic                peak_en,
    input  logic                peak_clr,
    input  logic                err,
    output word_t               word_o,
    output word_t               peak_o
);
    localparam int unsigned MAG_W = SAMPLE_W + 1;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                nd;
        logic [SAMPLE_W-1:0] peak;
    } chan_t;

    chan_t st_d, st_q;

    function automatic logic [MAG_W-1:0] mag(input logic [SAMPLE_W-1:0] v);
        logic [MAG_W-1:0] ext;
        ext = {v[SAMPLE_W-1], v};
        return v[SAMPLE_W-1] ? (~ext + MAG_W'(1)) : ext;
    endfunction

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = sample;
            st_d.nd   = 1'b1;
        end else if (rd) begin
            st_d.nd = 1'b0;
        end
        if (peak_clr) begin
            st_d.peak = '0;
        end else if (load && peak_en && (mag(sample) > mag(st_q.peak))) begin
            st_d.peak = sample;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word_o                 = '0;
        word_o[ND_POS]         = st_q.nd;
        word_o[EA_POS]         = err;
        word_o[SAMPLE_W-1:0]   = st_q.data;
        peak_o                 = '0;
        peak_o[SAMPLE_W-1:0]   = st_q.peak;
    end

    assert_nd_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> word_o[ND_POS]);
    assert_nd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> !word_o[ND_POS]);
    assert_peak_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_en && !peak_clr) |=> $stable(peak_o));
    assert_peak_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        peak_clr |=> (peak_o == '0));
    assert_peak_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_clr |=> (mag(peak_o[SAMPLE_W-1:0]) >= mag($past(peak_o[SAMPLE_W-1:0]))));
endmodule

// File: rtl/sos_tracker.sv
module sos_tracker
    import accel_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 10,
    parameter int unsigned NUM_AXES  = 3,
    parameter int unsigned SOS_W     = 12,
    parameter int unsigned SOS_SHIFT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         en,
    input  logic                         clr,
    input  logic [NUM_AXES*SAMPLE_W-1:0] samples,
    output word_t                        peak_o
);
    localparam int unsigned SQ_W    = 2 * SAMPLE_W;
    localparam int unsigned SUM_W   = SQ_W + $clog2(NUM_AXES) + 1;
    localparam logic [SOS_W-1:0] SOS_MAX = {SOS_W{1'b1}};

    typedef struct packed {
        logic [SOS_W-1:0] peak;
    } sos_t;

    sos_t st_d, st_q;
    logic [NUM_AXES-1:0][SQ_W-1:0] sq;
    logic [SUM_W-1:0]              sum;
    logic [SUM_W-1:0]              shifted;
    logic [SOS_W-1:0]              scaled;

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_square
        logic signed [SAMPLE_W-1:0] sv;
        logic signed [SQ_W-1:0]     prod;
        assign sv    = samples[g*SAMPLE_W +: SAMPLE_W];
        assign prod  = sv * sv;
        assign sq[g] = $unsigned(prod);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_AXES; i++) begin
            sum = sum + SUM_W'(sq[i]);
        end
        shifted = sum >> SOS_SHIFT;
        if (shifted > SUM_W'(SOS_MAX)) scaled = SOS_MAX;
        else                           scaled = shifted[SOS_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (clr)                                    st_d.peak = '0;
        else if (load && en && (scaled > st_q.peak)) st_d.peak = scaled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        peak_o              = '0;
        peak_o[SOS_W-1:0]   = st_q.peak;
    end

    assert_sos_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (peak_o >= $past(peak_o)));
    assert_sos_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(peak_o));
    assert_sos_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (peak_o == '0));
endmodule

// File: rtl/accel_sample_regs.sv
module accel_sample_regs
    import accel_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 10,
    parameter int unsigned NUM_AXES  = 3,
    parameter int unsigned SOS_W     = 12,
    parameter int unsigned SOS_SHIFT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_valid,
    input  logic [NUM_AXES*SAMPLE_W-1:0] sample_bus,
    input  logic [NUM_AXES-1:0]          rd_strobe,
    input  logic                         diag_err,
    input  logic                         peak_en,
    input  logic                         sos_en,
    input  logic                         peak_clr,
    output logic [NUM_AXES*WORD_W-1:0]   axis_words,
    output logic [NUM_AXES*WORD_W-1:0]   peak_words,
    output logic [WORD_W-1:0]            sos_word
);
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        word_t w, p;
        axis_channel #(.SAMPLE_W(SAMPLE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (sample_valid),
            .sample   (sample_bus[a*SAMPLE_W +: SAMPLE_W]),
            .rd       (rd_strobe[a]),
            .peak_en  (peak_en),
            .peak_clr (peak_clr),
            .err      (diag_err),
            .word_o   (w),
            .peak_o   (p)
        );
        assign axis_words[a*WORD_W +: WORD_W] = w;
        assign peak_words[a*WORD_W +: WORD_W] = p;

        assert_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_valid && rd_strobe[a]) |=> axis_words[a*WORD_W + ND_POS]);
    end

    sos_tracker #(
        .SAMPLE_W  (SAMPLE_W),
        .NUM_AXES  (NUM_AXES),
        .SOS_W     (SOS_W),
        .SOS_SHIFT (SOS_SHIFT)
    ) u_sos (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sample_valid),
        .en      (sos_en),
        .clr     (peak_clr),
        .samples (sample_bus),
        .peak_o  (sos_word)
    );
endmodule

// File: tb/tb_accel_sample_regs.sv
module tb_accel_sample_regs;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sample_valid = 0;
    logic [29:0] sample_bus = '0;
    logic [2:0]  rd_strobe = '0;
    logic        diag_err = 0, peak_en = 0, sos_en = 0, peak_clr = 0;
    logic [47:0] axis_words, peak_words;
    logic [15:0] sos_word;

    int checks = 0, errors = 0;
    bit done = 0;
    int mdata[3], mnd[3], mpk[3], msos;

    always #(PERIOD/2) clk = ~clk;

    accel_sample_regs dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_bus(sample_bus),
        .rd_strobe(rd_strobe), .diag_err(diag_err), .peak_en(peak_en), .sos_en(sos_en),
        .peak_clr(peak_clr), .axis_words(axis_words), .peak_words(peak_words), .sos_word(sos_word)
    );

    function automatic int sx(input int v);
        v = v & 32'h3FF;
        return (v >= 512) ? v - 1024 : v;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input int act, input int exp, input string req, input string ctx);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, ctx, act, exp, $time);
        end
    endtask

    task automatic compare(input string ctx);
        for (int a = 0; a < 3; a++) begin
            logic [15:0] w;
            w = axis_words[a*16 +: 16];
            chk(int'(w[15]), mnd[a], "R3", ctx);
            chk(int'(w[14]), int'(diag_err), "R5", ctx);
            chk(int'(w[13:10]), 0, "R1", ctx);
            chk(int'(w[9:0]), mdata[a] & 32'h3FF, "R2", ctx);
            chk(int'(peak_words[a*16 +: 16]), mpk[a] & 32'h3FF, "R7", ctx);
        end
        chk(int'(sos_word), msos, "R9", ctx);
    endtask

    task automatic step(input bit v, input int x, input int y, input int z, input logic [2:0] rd,
                        input bit err, input bit pe, input bit se, input bit clr, input string ctx);
        int s[3];
        s[0] = sx(x); s[1] = sx(y); s[2] = sx(z);
        sample_valid = v;
        sample_bus = {10'(z), 10'(y), 10'(x)};
        rd_strobe = rd; diag_err = err; peak_en = pe; sos_en = se; peak_clr = clr;
        @(posedge clk);
        for (int a = 0; a < 3; a++) begin
            if (v) begin mdata[a] = s[a]; mnd[a] = 1; end
            else if (rd[a]) mnd[a] = 0;
            if (clr) mpk[a] = 0;
            else if (v && pe && iabs(s[a]) > iabs(mpk[a])) mpk[a] = s[a];
        end
        if (clr) msos = 0;
        else if (v && se) begin
            int c;
            c = (s[0]*s[0] + s[1]*s[1] + s[2]*s[2]) >> 8;
            if (c > 4095) c = 4095;
            if (c > msos) msos = c;
        end
        @(negedge clk);
        compare(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 3; a++) begin mdata[a] = 0; mnd[a] = 0; mpk[a] = 0; end
        msos = 0;
        repeat (3) @(negedge clk);
        compare("R6 during reset");
        rst_n = 1;
        compare("R6 after reset");
        // R2 R7 R9: first capture with both peak kinds enabled
        step(1, 'h137, 'h3FF, 'h2C9, 3'b000, 0, 1, 1, 0, "R2 first sample");
        // R3: read axis 1 only, others keep their flag
        step(0, 0, 0, 0, 3'b010, 0, 1, 1, 0, "R3 read y");
        step(0, 0, 0, 0, 3'b101, 1, 1, 1, 0, "R3 read x z R5");
        // R4: read collides with update
        step(1, 'h002, 'h001, 'h000, 3'b111, 1, 1, 1, 0, "R4 collision");
        // R7: equal magnitude opposite sign keeps earlier (+311 vs -311)
        step(1, 'h2C9, 'h137, 'h137, 3'b000, 0, 1, 1, 0, "R7 equal magnitude");
        // R7: most negative code, magnitude 512
        step(1, 'h200, 'h1FF, 'h200, 3'b000, 0, 1, 1, 0, "R7 most negative");
        step(1, 'h1FF, 'h201, 'h1FF, 3'b000, 0, 1, 1, 0, "R7 smaller after max");
        // R11: clear with simultaneous capture
        step(1, 'h100, 'h100, 'h100, 3'b000, 0, 1, 1, 1, "R11 clear priority");
        // R8 R10: captures disabled
        step(1, 'h1F0, 'h210, 'h1F0, 3'b000, 0, 0, 0, 0, "R8 R10 disabled");
        step(1, 'h010, 'h3F0, 'h005, 3'b000, 1, 1, 0, 0, "R10 sos off, peak on");
        step(1, 'h200, 'h200, 'h200, 3'b000, 0, 0, 1, 0, "R8 peak off, sos on");
        step(0, 0, 0, 0, 3'b000, 0, 1, 1, 1, "R11 clear idle");
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 3) != 0, int'($urandom), int'($urandom), int'($urandom),
                 3'($urandom), ($urandom % 4) == 0, ($urandom % 4) != 0,
                 ($urandom % 4) != 0, ($urandom % 40) == 0, "R1 random");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule